// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block performs the one-time start-up ritual an SDRAM device needs before it may accept reads or writes. It stays quiet, driving a no-operation command, until an external flag reports that the clock and supply stabilization period has elapsed. The delay itself is timed elsewhere. The block then walks a fixed command order. It first issues a single NOP cycle and then a precharge that selects every bank. Two auto-refresh commands follow, and the sequence ends with a load of the mode register. A programmable count of NOP cycles follows each command. When the last wait has run out, the block raises a sticky done flag. A memory controller uses that flag as permission to start normal traffic.

Each command is driven on four active-low strobes packed as {chip select, row strobe, column strobe, write enable}. A separate pin drives address line 10 high during the precharge so that all banks are affected. A mode bus carries the configured mode word, which holds the burst length, burst type and CAS latency, but only in the cycle of the mode-register load. The pins are plain control outputs with no handshake, because the memory device cannot push back on commands.

Top module: `sdram_powerup_seq`

## Requirements
- R1: After a synchronous active-high reset, and for as long as `pwr_stable_i` stays low, the block drives NOP (`cmd_o` = 4'b0111) with `a10_o` = 0, `mode_addr_o` = 0 and `init_done_o` = 0.
- R2: When `pwr_stable_i` is first sampled high in the idle state, the next cycle shows a NOP. The cycle after that shows one cycle of precharge (`cmd_o` = 4'b0010) with `a10_o` = 1.
- R3: The precharge is followed by exactly `T_RP` NOP cycles, and the first auto-refresh (`cmd_o` = 4'b0001) comes next.
- R4: Exactly two auto-refresh commands are issued. Each lasts one cycle and is followed by exactly `T_RFC` NOP cycles.
- R5: After the second refresh wait, a one-cycle mode-register load (`cmd_o` = 4'b0000) is issued with `mode_addr_o` = `MODE_VALUE`. In every other cycle `mode_addr_o` is 0.
- R6: After the mode-register load, exactly `T_MRD` NOP cycles pass. `init_done_o` then rises and stays high with `cmd_o` = NOP until reset.
- R7: A reset asserted at any point in the sequence returns the block to the R1 state on the next clock edge, which clears `init_done_o`.
- R8: Once the sequence has left idle, `pwr_stable_i` has no effect on `cmd_o`, `a10_o`, `mode_addr_o` or `init_done_o`.
- R9: `a10_o` is high only in the precharge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pwr_stable_i | input | 1 | High once the external stabilization delay has elapsed |
| cmd_o | output | 4 | Command strobes {CS#, RAS#, CAS#, WE#}, active low |
| a10_o | output | 1 | Address line 10; high selects all banks during precharge |
| mode_addr_o | output | MODE_W | Mode word during the mode-register load, zero otherwise |
| init_done_o | output | 1 | Sticky flag: initialization complete |

## Verification
The sequence is started in three ways, and each separates a different class of fault. In the first, the stable flag is held high for the whole run. In the second, the flag is pulsed for a single cycle, which exposes a design that needs the flag to stay high. In the third, the flag is already high when reset is released, which exposes a design that acts on an edge of the flag rather than on its level. While the block is running and again after done, the flag is toggled irregularly to show that it no longer has any effect. A reset applied during a refresh wait shows that the counters and the done flag are cleared. The bench uses a minimum precharge wait of one cycle, so an off-by-one in the wait counter moves the refresh command and cannot go unnoticed.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_NOP,
    ST_PRE,
    ST_WAIT_RP,
    ST_REF1,
    ST_WAIT_RF1,
    ST_REF2,
    ST_WAIT_RF2,
    ST_MRS,
    ST_WAIT_MRD,
    ST_DONE
  } init_state_e;

  // {CS#, RAS#, CAS#, WE#}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_LMR = 4'b0000;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int T_RP  = 2,
  parameter int T_RFC = 8,
  parameter int T_MRD = 2,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stable,
  input  logic             expired,
  output init_state_e      state,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);

  localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RFC_LOAD = CNT_W'(T_RFC - 1);
  localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'(T_MRD - 1);

  init_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE:     if (stable) state_d = ST_NOP;
      ST_NOP:      state_d = ST_PRE;
      ST_PRE: begin
        load     = 1'b1;
        load_val = RP_LOAD;
        state_d  = ST_WAIT_RP;
      end
      ST_WAIT_RP:  if (expired) state_d = ST_REF1;
      ST_REF1: begin
        load     = 1'b1;
        load_val = RFC_LOAD;
        state_d  = ST_WAIT_RF1;
      end
      ST_WAIT_RF1: if (expired) state_d = ST_REF2;
      ST_REF2: begin
        load     = 1'b1;
        load_val = RFC_LOAD;
        state_d  = ST_WAIT_RF2;
      end
      ST_WAIT_RF2: if (expired) state_d = ST_MRS;
      ST_MRS: begin
        load     = 1'b1;
        load_val = MRD_LOAD;
        state_d  = ST_WAIT_MRD;
      end
      ST_WAIT_MRD: if (expired) state_d = ST_DONE;
      ST_DONE:     state_d = ST_DONE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/sdram_init_cmd_drv.sv
module sdram_init_cmd_drv
  import sdram_init_pkg::*;
#(
  parameter int               MODE_W     = 10,
  parameter logic [MODE_W-1:0] MODE_VALUE = '0
) (
  input  init_state_e        state,
  output logic [3:0]         cmd,
  output logic               a10,
  output logic [MODE_W-1:0]  mode_addr,
  output logic               done
);

  always_comb begin
    cmd       = CMD_NOP;
    a10       = 1'b0;
    mode_addr = '0;
    done      = 1'b0;
    unique case (state)
      ST_PRE: begin
        cmd = CMD_PRE;
        a10 = 1'b1;
      end
      ST_REF1, ST_REF2: cmd = CMD_REF;
      ST_MRS: begin
        cmd       = CMD_LMR;
        mode_addr = MODE_VALUE;
      end
      ST_DONE: done = 1'b1;
      default: cmd = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdram_init_pkg::*;
#(
  parameter int                T_RP       = 2,
  parameter int                T_RFC      = 8,
  parameter int                T_MRD      = 2,
  parameter int                MODE_W     = 10,
  parameter logic [MODE_W-1:0] MODE_VALUE = MODE_W'(10'h032)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_stable_i,
  output logic [3:0]        cmd_o,
  output logic              a10_o,
  output logic [MODE_W-1:0] mode_addr_o,
  output logic              init_done_o
);

  localparam int T_MAX1 = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int T_MAX  = (T_MAX1 > T_MRD) ? T_MAX1 : T_MRD;
  localparam int CNT_W  = (T_MAX > 1) ? $clog2(T_MAX) : 1;

  init_state_e      state;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;

  sdram_init_fsm #(
    .T_RP (T_RP),
    .T_RFC(T_RFC),
    .T_MRD(T_MRD),
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .stable  (pwr_stable_i),
    .expired (expired),
    .state   (state),
    .load    (load),
    .load_val(load_val)
  );

  sdram_init_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_val(load_val),
    .expired (expired)
  );

  sdram_init_cmd_drv #(
    .MODE_W    (MODE_W),
    .MODE_VALUE(MODE_VALUE)
  ) u_drv (
    .state    (state),
    .cmd      (cmd_o),
    .a10      (a10_o),
    .mode_addr(mode_addr_o),
    .done     (init_done_o)
  );

endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk
  import sdram_init_pkg::*;
#(
  parameter int                T_RP       = 2,
  parameter int                T_RFC      = 8,
  parameter int                T_MRD      = 2,
  parameter int                MODE_W     = 10,
  parameter logic [MODE_W-1:0] MODE_VALUE = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        cmd_o,
  input logic              a10_o,
  input logic [MODE_W-1:0] mode_addr_o,
  input logic              init_done_o
);

  int         gap_q;
  logic [3:0] last_cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q      <= 0;
      last_cmd_q <= CMD_NOP;
    end else if (cmd_o == CMD_NOP) begin
      gap_q <= gap_q + 1;
    end else begin
      gap_q      <= 0;
      last_cmd_q <= cmd_o;
    end
  end

  // R3
  rp_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_REF && last_cmd_q == CMD_PRE) |-> gap_q == T_RP);

  // R4
  rfc_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_LMR) |-> (last_cmd_q == CMD_REF && gap_q == T_RFC));

  // R4
  ref_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_REF) |=> cmd_o == CMD_NOP);

  // R5
  mode_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_addr_o != '0) |-> (cmd_o == CMD_LMR && mode_addr_o == MODE_VALUE));

  // R6
  mrd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done_o) |-> (last_cmd_q == CMD_LMR && gap_q == T_MRD));

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    init_done_o |=> (init_done_o && cmd_o == CMD_NOP));

  // R7
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!init_done_o && cmd_o == CMD_NOP));

  // R9
  a10_only_pre_chk: assert property (@(posedge clk) disable iff (rst)
    a10_o |-> cmd_o == CMD_PRE);

endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(
  .T_RP      (T_RP),
  .T_RFC     (T_RFC),
  .T_MRD     (T_MRD),
  .MODE_W    (MODE_W),
  .MODE_VALUE(MODE_VALUE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_o      (cmd_o),
  .a10_o      (a10_o),
  .mode_addr_o(mode_addr_o),
  .init_done_o(init_done_o)
);

// File: tb/test_sdram_powerup_seq.sv
`timescale 1ns/1ps
module test_sdram_powerup_seq;

  localparam int         RP   = 1;
  localparam int         RFC  = 4;
  localparam int         MRD  = 2;
  localparam int         MW   = 10;
  localparam logic [9:0] MODE = 10'h032;

  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] LMR = 4'b0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stable = 1'b0;
  logic [3:0]    cmd;
  logic          a10;
  logic [MW-1:0] maddr;
  logic          done;

  always #2 clk = ~clk;

  sdram_powerup_seq #(
    .T_RP(RP), .T_RFC(RFC), .T_MRD(MRD), .MODE_W(MW), .MODE_VALUE(MODE)
  ) i_sdram_powerup_seq (
    .clk(clk), .rst(rst), .pwr_stable_i(stable),
    .cmd_o(cmd), .a10_o(a10), .mode_addr_o(maddr), .init_done_o(done)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    cmp_en = 0;
  bit    finished = 0;
  string tag_override = "";

  // reference model: entry = {done, a10, cmd}
  logic [5:0] sched[$];
  logic [5:0] exp_e = {2'b00, NOP};
  bit         started = 0;

  task automatic push_n(input logic [5:0] e, input int n);
    for (int i = 0; i < n; i++) sched.push_back(e);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      sched.delete();
      started = 0;
      exp_e   = {2'b00, NOP};
    end else if (!started) begin
      if (stable) begin
        started = 1;
        push_n({2'b00, NOP}, 1);
        push_n({2'b01, PRE}, 1);
        push_n({2'b00, NOP}, RP);
        push_n({2'b00, REF}, 1);
        push_n({2'b00, NOP}, RFC);
        push_n({2'b00, REF}, 1);
        push_n({2'b00, NOP}, RFC);
        push_n({2'b00, LMR}, 1);
        push_n({2'b00, NOP}, MRD);
        exp_e = sched.pop_front();
      end
    end else if (sched.size() > 0) begin
      exp_e = sched.pop_front();
    end else begin
      exp_e = {2'b10, NOP};
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      string         tag;
      logic [MW-1:0] exp_addr;
      exp_addr = (exp_e[3:0] == LMR) ? MODE : '0;
      if (tag_override != "")    tag = tag_override;
      else if (exp_e[5])         tag = "R6";
      else if (exp_e[3:0] == PRE) tag = "R2 R9";
      else if (exp_e[3:0] == REF) tag = "R4";
      else if (exp_e[3:0] == LMR) tag = "R5";
      else if (started)          tag = "R3";
      else                       tag = "R1";
      checks++;
      if (cmd !== exp_e[3:0] || a10 !== exp_e[4] || maddr !== exp_addr || done !== exp_e[5]) begin
        fails++;
        $display("FAIL %s at %0t: cmd=%b a10=%b addr=%h done=%b, expected cmd=%b a10=%b addr=%h done=%b",
                 tag, $time, cmd, a10, maddr, done, exp_e[3:0], exp_e[4], exp_addr, exp_e[5]);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    cmp_en = 1;                 // R1 reset state
    cycles(2);
    rst = 0;
    tag_override = "R1";
    cycles(8);                  // idle with stable low
    tag_override = "";
    stable = 1;                 // scenario 1: level held high
    cycles(8);
    tag_override = "R8";
    for (int i = 0; i < 30; i++) begin
      stable = (i % 3 == 1);
      @(negedge clk);
    end
    tag_override = "";
    // scenario 2: single-cycle pulse, reset during refresh wait
    rst = 1; stable = 0;
    cycles(1);
    rst = 0;
    cycles(2);
    stable = 1;
    cycles(1);
    stable = 0;
    cycles(6);
    rst = 1;
    tag_override = "R7";
    cycles(1);
    rst = 0;
    cycles(5);
    tag_override = "";
    stable = 1;
    cycles(1);
    stable = 0;
    cycles(25);
    // scenario 3: stable already high at reset release
    rst = 1; stable = 1;
    cycles(2);
    rst = 0;
    cycles(25);
    finished = 1;
    summary();
  end

  initial begin
    #800000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
    end
  end

endmodule